// File: doc/BRIEF.md
# Programmable-Depth Fall-Through FIFO

This block is a first-in first-out buffer that holds up to 32 words of 9 bits each. Its usable capacity is fixed at each reset. A small limit register holds a 5-bit value X. A falling edge on an active-low define strobe loads X from the low five data-input bits. While the reset pulse is low, a select input chooses the capacity: either 32 minus X, or the full 32 words. X is kept across resets, so one value can be reused by many later resets.

The output is fall-through. The oldest stored word is always on the data output, so the first word written into an empty buffer shows up without any unload. An unload only moves on to the next word. Two active-low flags report the full and empty conditions. The whole block runs on one system clock, and load and unload are single-cycle enables.

Top module: `prog_depth_fifo`

## Requirements
- R1: While rst_n is low at a rising clock edge, the pointers and the stored-word count are cleared. After that edge, empty_n is 0 and full_n is 1. dout is not forced to any value.
- R2: The limit register X takes din[4:0] at the first clock edge where define_n is seen low after being high. Keeping define_n low on later edges captures nothing more.
- R3: At a reset edge with full_sel = 0, the capacity becomes 32 - X words (X = 0 gives 32, X = 31 gives 1). With full_sel = 1, the capacity becomes 32 words.
- R4: full_n is 0 exactly when the stored-word count equals the capacity.
- R5: empty_n is 0 exactly when no words are stored.
- R6: A load while full_n is 0 does not change the stored words or their count.
- R7: An unload while empty_n is 0 has no effect: dout and the flags keep their values.
- R8: A load into an empty buffer raises empty_n and shows that word on dout one clock edge later, with no unload.
- R9: An unload that leaves words stored shows the next word on dout after the edge. An unload of the last word drives empty_n low and leaves dout at the value it last had.
- R10: A load and an unload in the same cycle, with the buffer neither full nor empty, leave the count unchanged. Word order is kept.
- R11: Words leave in the order they were loaded.
- R12: X is not changed by reset. A later reset with full_sel = 0 uses the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset pulse |
| load | input | 1 | Write enable for din |
| unload | input | 1 | Advance to the next stored word |
| define_n | input | 1 | Active-low strobe; its falling edge captures X from din[4:0] |
| full_sel | input | 1 | Capacity select at reset: 1 = 32 words, 0 = 32 - X |
| din | input | 9 | Write data; bits 4:0 also carry X |
| dout | output | 9 | Oldest stored word (fall-through) |
| full_n | output | 1 | Low when the count equals the capacity |
| empty_n | output | 1 | Low when no words are stored |

## Verification
The hardest states to reach are a full buffer at the small capacities and the case where the last word leaves in the same cycle another arrives. The stimulus programs X to 29, 31 and 30 so that the buffer fills in a few loads. It then checks that an extra load is dropped by draining the buffer and comparing every word that leaves. A vector sequence at capacity 32 covers the combined load-and-unload on one stored word, which must put the new word straight on the output.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
    localparam int unsigned PF_DATA_W = 9;
    localparam int unsigned PF_ADDR_W = 5;

    // capacity chosen at reset: whole array, or array minus the captured limit
    function automatic int unsigned pick_capacity(int unsigned words, int unsigned lim, logic whole);
        return whole ? words : words - lim;
    endfunction
endpackage

// File: rtl/pfifo_limit.sv
module pfifo_limit #(
    parameter int unsigned ADDR_W = pfifo_pkg::PF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              define_n,
    input  logic [ADDR_W-1:0] din_lo,
    input  logic              full_sel,
    output logic [ADDR_W:0]   cap_o
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] lim;
        logic              def;
        logic [ADDR_W:0]   cap;
    } lim_state_t;

    lim_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.def = define_n;
        if (s_q.def && !define_n)
            s_d.lim = din_lo;
        if (!rst_n)
            s_d.cap = (ADDR_W+1)'(pfifo_pkg::pick_capacity(WORDS, int'(s_q.lim), full_sel));
    end

    // the limit register survives reset on purpose
    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cap_o = s_q.cap;

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(define_n) == 1'b1 && s_q.def && !define_n) |=> (s_q.lim == $past(din_lo)));
    p_cap_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (s_q.cap >= 1 && s_q.cap <= (ADDR_W+1)'(WORDS)));
    p_lim_kept_r12: assert property (@(posedge clk)
        (!rst_n && !(s_q.def && !define_n)) |=> $stable(s_q.lim));
endmodule

// File: rtl/pfifo_store.sv
module pfifo_store #(
    parameter int unsigned DATA_W = pfifo_pkg::PF_DATA_W,
    parameter int unsigned ADDR_W = pfifo_pkg::PF_ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl #(
    parameter int unsigned DATA_W = pfifo_pkg::PF_DATA_W,
    parameter int unsigned ADDR_W = pfifo_pkg::PF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              unload,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W:0]   cap_i,
    input  logic [DATA_W-1:0] next_word_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [ADDR_W-1:0] naddr_o,
    output logic [DATA_W-1:0] dout,
    output logic              full_n,
    output logic              empty_n
);
    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W:0]   cnt;
        logic [DATA_W-1:0] head;
        logic              full_n;
        logic              empty_n;
    } ctl_state_t;

    ctl_state_t s_d, s_q;
    logic       wr_ok, rd_ok;

    always_comb begin
        wr_ok = load && (s_q.cnt != cap_i);
        rd_ok = unload && (s_q.cnt != '0);
        s_d   = s_q;
        if (wr_ok) s_d.wr = s_q.wr + 1'b1;
        if (rd_ok) s_d.rd = s_q.rd + 1'b1;
        unique case ({wr_ok, rd_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        // fall-through head word
        if (rd_ok) begin
            if (s_q.cnt >= 2)  s_d.head = next_word_i;
            else if (wr_ok)    s_d.head = din;
        end else if (wr_ok && s_q.cnt == '0) begin
            s_d.head = din;
        end
        s_d.full_n  = (s_d.cnt != cap_i);
        s_d.empty_n = (s_d.cnt != '0);
        if (!rst_n) begin
            s_d.wr      = '0;
            s_d.rd      = '0;
            s_d.cnt     = '0;
            s_d.full_n  = 1'b1;
            s_d.empty_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign we_o    = wr_ok;
    assign waddr_o = s_q.wr;
    assign naddr_o = s_q.rd + 1'b1;
    assign dout    = s_q.head;
    assign full_n  = s_q.full_n;
    assign empty_n = s_q.empty_n;

    p_reset_flags_r1: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && full_n));
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s_q.cnt <= cap_i));
    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n));
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && load && !unload) |=> ($stable(s_q.wr) && $stable(s_q.cnt)));
    p_empty_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && unload && !load) |=> ($stable(s_q.rd) && $stable(dout) && !empty_n));
    p_fall_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && load) |=> (empty_n && dout == $past(din)));
    p_swap_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && unload && empty_n && full_n) |=> $stable(s_q.cnt));
endmodule

// File: rtl/prog_depth_fifo.sv
module prog_depth_fifo (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       unload,
    input  logic       define_n,
    input  logic       full_sel,
    input  logic [8:0] din,
    output logic [8:0] dout,
    output logic       full_n,
    output logic       empty_n
);
    localparam int unsigned DATA_W = pfifo_pkg::PF_DATA_W;
    localparam int unsigned ADDR_W = pfifo_pkg::PF_ADDR_W;

    logic [ADDR_W:0]   cap;
    logic              we;
    logic [ADDR_W-1:0] waddr, naddr;
    logic [DATA_W-1:0] next_word;

    pfifo_limit #(.ADDR_W(ADDR_W)) limit_i (
        .clk(clk), .rst_n(rst_n), .define_n(define_n),
        .din_lo(din[ADDR_W-1:0]), .full_sel(full_sel), .cap_o(cap)
    );

    pfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk(clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(naddr), .rdata(next_word)
    );

    pfifo_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .load(load), .unload(unload), .din(din),
        .cap_i(cap), .next_word_i(next_word), .we_o(we), .waddr_o(waddr),
        .naddr_o(naddr), .dout(dout), .full_n(full_n), .empty_n(empty_n)
    );
endmodule

// File: tb/prog_depth_fifo_tb_top.sv
`timescale 1ns/1ps
module prog_depth_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, load = 1'b0, unload = 1'b0, define_n = 1'b1, full_sel = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       full_n, empty_n;
    int         errors = 0, checks = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    prog_depth_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .unload(unload), .define_n(define_n),
        .full_sel(full_sel), .din(din), .dout(dout), .full_n(full_n), .empty_n(empty_n)
    );

    typedef struct packed {
        logic       ld;
        logic       ul;
        logic [8:0] d;
        logic [8:0] q;
        logic       e;
        logic       f;
    } vec_t;

    // capacity 32; order and fall-through (R8 R9 R10 R11), empty unload (R7)
    localparam vec_t VEC [11] = '{
        '{1'b1, 1'b0, 9'h101, 9'h101, 1'b1, 1'b1},
        '{1'b1, 1'b0, 9'h0a2, 9'h101, 1'b1, 1'b1},
        '{1'b1, 1'b0, 9'h1c3, 9'h101, 1'b1, 1'b1},
        '{1'b0, 1'b1, 9'h000, 9'h0a2, 1'b1, 1'b1},
        '{1'b1, 1'b1, 9'h044, 9'h1c3, 1'b1, 1'b1},
        '{1'b0, 1'b1, 9'h000, 9'h044, 1'b1, 1'b1},
        '{1'b0, 1'b1, 9'h000, 9'h044, 1'b0, 1'b1},
        '{1'b0, 1'b1, 9'h000, 9'h044, 1'b0, 1'b1},
        '{1'b1, 1'b1, 9'h155, 9'h155, 1'b1, 1'b1},
        '{1'b1, 1'b1, 9'h0ff, 9'h0ff, 1'b1, 1'b1},
        '{1'b0, 1'b1, 9'h000, 9'h0ff, 1'b0, 1'b1}
    };

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(logic ld, logic ul, logic [8:0] d);
        @(negedge clk);
        load = ld; unload = ul; din = d;
        @(posedge clk); #1;
        load = 1'b0; unload = 1'b0;
    endtask

    task automatic do_reset(logic sel);
        @(negedge clk);
        rst_n = 1'b0; full_sel = sel;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic define_lim(logic [8:0] d);
        @(negedge clk);
        define_n = 1'b0; din = d;
        @(posedge clk); #1;
        define_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        do_reset(1'b1);
        check("R1 empty_n after reset", 9'(empty_n), 9'd0);
        check("R1 full_n after reset", 9'(full_n), 9'd1);
        cycle(1'b0, 1'b1, 9'h0);
        check("R7 unload on empty keeps empty_n", 9'(empty_n), 9'd0);

        foreach (VEC[i]) begin
            cycle(VEC[i].ld, VEC[i].ul, VEC[i].d);
            check($sformatf("R11 vec%0d dout", i), dout, VEC[i].q);
            check($sformatf("R5 vec%0d empty_n", i), 9'(empty_n), 9'(VEC[i].e));
            check($sformatf("R4 vec%0d full_n", i), 9'(full_n), 9'(VEC[i].f));
        end

        // X = 29 with stray upper bits -> capacity 3
        define_lim(9'h1fd);
        do_reset(1'b0);
        check("R1 empty_n after reset two", 9'(empty_n), 9'd0);
        cycle(1'b1, 1'b0, 9'h011);
        check("R8 first word falls through", dout, 9'h011);
        cycle(1'b1, 1'b0, 9'h022);
        check("R4 full_n at two of three", 9'(full_n), 9'd1);
        cycle(1'b1, 1'b0, 9'h033);
        check("R3 full_n low at 32-X", 9'(full_n), 9'd0);
        cycle(1'b1, 1'b0, 9'h0ee);
        check("R6 full_n stays low", 9'(full_n), 9'd0);
        check("R6 head unchanged", dout, 9'h011);
        cycle(1'b0, 1'b1, 9'h0);
        check("R9 next word", dout, 9'h022);
        check("R4 full_n released", 9'(full_n), 9'd1);
        cycle(1'b0, 1'b1, 9'h0);
        check("R9 third word", dout, 9'h033);
        cycle(1'b0, 1'b1, 9'h0);
        check("R9 last unload holds dout", dout, 9'h033);
        check("R6 dropped word absent, empty", 9'(empty_n), 9'd0);

        // X kept through another reset
        do_reset(1'b0);
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 9'(k + 5));
        check("R12 capacity still 3 after reset", 9'(full_n), 9'd0);

        // X = 31 -> capacity 1
        define_lim(9'h01f);
        do_reset(1'b0);
        cycle(1'b1, 1'b0, 9'h1aa);
        check("R3 capacity one full", 9'(full_n), 9'd0);
        check("R8 single word shown", dout, 9'h1aa);

        // define held low: only the falling edge captures (30 -> capacity 2)
        @(negedge clk); define_n = 1'b0; din = 9'd30;
        @(posedge clk); #1; din = 9'd0;
        @(posedge clk); #1; define_n = 1'b1;
        do_reset(1'b0);
        cycle(1'b1, 1'b0, 9'h001);
        check("R2 one word not full", 9'(full_n), 9'd1);
        cycle(1'b1, 1'b0, 9'h002);
        check("R2 held strobe ignored, full at two", 9'(full_n), 9'd0);

        // full_sel high -> 32 words regardless of X
        do_reset(1'b1);
        for (int k = 0; k < 31; k++) cycle(1'b1, 1'b0, 9'(k + 64));
        check("R3 31 words not full", 9'(full_n), 9'd1);
        cycle(1'b1, 1'b0, 9'h1ff);
        check("R3 32 words full", 9'(full_n), 9'd0);
        cycle(1'b1, 1'b1, 9'h000);
        check("R6 load dropped while full, unload taken", 9'(full_n), 9'd1);
        check("R11 second word at head", dout, 9'd65);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule